// File: doc/BRIEF.md
# Selectable Ready/Valid Channel Buffer

This block sits on one ready/valid channel at the boundary of a pipelined design and decouples the producer from the consumer. One parameter picks which of three buffering disciplines is built. The first is a one-entry register stage that always adds a cycle of latency. The second is a two-entry skid buffer whose upstream ready comes straight from a flop. The third is a one-entry buffer that forwards a word in the same cycle when nothing is stored.

Every variant has the same handshake on both sides. A word moves on a side only in a cycle where that side's valid and ready are both high. Words leave in the order they arrived, and none is lost or repeated, whatever the stall pattern. An idle flag is high when no entry is held and no word is offered upstream. Surrounding logic can use this flag to gate clocks or to detect that the pipeline has drained.

Top module: `chan_buf`

## Requirements
- R1: A word is accepted upstream only in a cycle with up_valid and up_ready both high, and delivered downstream only in a cycle with dn_valid and dn_ready both high. A stalled dn_valid stays high and its dn_data stays unchanged until the word is taken.
- R2: Words are delivered in acceptance order, each exactly once, in every mode and under any pattern of up_valid and dn_ready.
- R3: Mode 0 (register stage) holds at most one word. dn_valid is high exactly when a word accepted in an earlier cycle is still held, so every word spends at least one cycle in the buffer.
- R4: Mode 1 (skid) holds at most two words. dn_valid is high exactly when at least one word is held. up_ready is driven from a flop and is high exactly when fewer than two words are held.
- R5: Mode 2 (bypass) forwards combinationally. When nothing is held, dn_valid follows up_valid in the same cycle and dn_data equals up_data. When a word is held, that word is presented first.
- R6: Mode 2 holds at most one word.
- R7: idle is high exactly when no word is held and up_valid is low.
- R8: Synchronous reset (rst high at a clock edge) empties the buffer, so after reset dn_valid is low and idle follows only up_valid.
- R9: In modes 0 and 2, up_ready is high exactly when nothing is held or dn_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| up_valid | input | 1 | Producer offers a word |
| up_ready | output | 1 | Buffer can accept a word |
| up_data | input | WIDTH | Offered word |
| dn_valid | output | 1 | Buffer presents a word |
| dn_ready | input | 1 | Consumer takes the presented word |
| dn_data | output | WIDTH | Presented word |
| idle | output | 1 | No word held and none offered |

## Verification
In mode 2, the downstream outputs and up_ready respond to up_valid and dn_ready in the same cycle. In mode 0 and mode 1, the downstream outputs follow the held state, which changes at the clock edge after each transfer. The skid variant's up_ready also follows the held state, one edge after each transfer. The bench drives inputs just after the rising edge and checks the outputs at the falling edge. It computes each expected value from a model occupancy, the words accepted minus the words delivered up to that edge, together with the inputs of the current cycle. Each transfer is then counted into the model for the next edge. All three modes run side by side on independent random stimulus, which passes through phases of heavy stall, drain and full streaming.

// File: rtl/chan_buf_pkg.sv
package chan_buf_pkg;

    localparam int MODE_STAGE  = 0;
    localparam int MODE_SKID   = 1;
    localparam int MODE_BYPASS = 2;

    // Largest number of words any variant can hold.
    localparam int MAX_SLOTS = 2;

    function automatic int slots_of(input int mode);
        return (mode == MODE_SKID) ? 2 : 1;
    endfunction

endpackage

// File: rtl/chan_buf_stage.sv
module chan_buf_stage #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             up_valid,
    output logic             up_ready,
    input  logic [WIDTH-1:0] up_data,
    output logic             dn_valid,
    input  logic             dn_ready,
    output logic [WIDTH-1:0] dn_data,
    output logic [1:0]       held
);

    typedef struct packed {
        logic             v;
        logic [WIDTH-1:0] d;
    } stage_t;

    stage_t st_d, st_q;

    assign up_ready = !st_q.v || dn_ready;
    assign dn_valid = st_q.v;
    assign dn_data  = st_q.d;
    assign held     = {1'b0, st_q.v};

    always_comb begin
        st_d = st_q;
        if (st_q.v && dn_ready) begin
            st_d.v = 1'b0;
        end
        if (up_valid && up_ready) begin
            st_d.v = 1'b1;
            st_d.d = up_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R1: a stalled word is held steady
    a_r1_hold_stall: assert property (@(posedge clk) disable iff (rst)
        dn_valid && !dn_ready |=> dn_valid && $stable(dn_data));

    // R3: output only appears after an upstream transfer in an earlier cycle
    a_r3_min_latency: assert property (@(posedge clk) disable iff (rst)
        $rose(dn_valid) |-> $past(up_valid && up_ready));

endmodule

// File: rtl/chan_buf_skid.sv
module chan_buf_skid #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             up_valid,
    output logic             up_ready,
    input  logic [WIDTH-1:0] up_data,
    output logic             dn_valid,
    input  logic             dn_ready,
    output logic [WIDTH-1:0] dn_data,
    output logic [1:0]       held
);

    typedef struct packed {
        logic             main_v;
        logic [WIDTH-1:0] main_d;
        logic             spare_v;
        logic [WIDTH-1:0] spare_d;
        logic             rdy;
    } skid_t;

    skid_t sk_d, sk_q;
    logic  out_fire;
    logic  in_fire;
    logic  main_free;

    assign up_ready = sk_q.rdy;
    assign dn_valid = sk_q.main_v;
    assign dn_data  = sk_q.main_d;
    assign held     = {sk_q.spare_v, sk_q.main_v};

    always_comb begin
        out_fire  = sk_q.main_v && dn_ready;
        in_fire   = up_valid && sk_q.rdy;
        main_free = !sk_q.main_v || out_fire;
        sk_d      = sk_q;
        if (sk_q.spare_v) begin
            // Upstream is stalled; move the spare word forward once room opens.
            if (main_free) begin
                sk_d.main_v  = 1'b1;
                sk_d.main_d  = sk_q.spare_d;
                sk_d.spare_v = 1'b0;
            end
        end else if (in_fire) begin
            if (main_free) begin
                sk_d.main_v = 1'b1;
                sk_d.main_d = up_data;
            end else begin
                sk_d.spare_v = 1'b1;
                sk_d.spare_d = up_data;
            end
        end else if (out_fire) begin
            sk_d.main_v = 1'b0;
        end
        sk_d.rdy = !sk_d.spare_v;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sk_q     <= '0;
            sk_q.rdy <= 1'b1;
        end else begin
            sk_q <= sk_d;
        end
    end

    // R1: a stalled word is held steady
    a_r1_hold_stall: assert property (@(posedge clk) disable iff (rst)
        dn_valid && !dn_ready |=> dn_valid && $stable(dn_data));

    // R4: registered ready only reopens after a downstream transfer
    a_r4_ready_reopen: assert property (@(posedge clk) disable iff (rst)
        $rose(up_ready) |-> $past(dn_valid && dn_ready));

    // R4: never accept while both slots are occupied
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        up_valid && up_ready |-> !sk_q.spare_v);

endmodule

// File: rtl/chan_buf_bypass.sv
module chan_buf_bypass #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             up_valid,
    output logic             up_ready,
    input  logic [WIDTH-1:0] up_data,
    output logic             dn_valid,
    input  logic             dn_ready,
    output logic [WIDTH-1:0] dn_data,
    output logic [1:0]       held
);

    typedef struct packed {
        logic             v;
        logic [WIDTH-1:0] d;
    } byp_t;

    byp_t bp_d, bp_q;

    assign up_ready = !bp_q.v || dn_ready;
    assign dn_valid = bp_q.v || up_valid;
    assign dn_data  = bp_q.v ? bp_q.d : up_data;
    assign held     = {1'b0, bp_q.v};

    always_comb begin
        bp_d = bp_q;
        if (bp_q.v && dn_ready) begin
            bp_d.v = 1'b0;
        end
        if (up_valid && up_ready && !(!bp_q.v && dn_ready)) begin
            // Word cannot flow straight through this cycle; keep it.
            bp_d.v = 1'b1;
            bp_d.d = up_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bp_q <= '0;
        end else begin
            bp_q <= bp_d;
        end
    end

    // R5: empty storage passes the offered word through in the same cycle
    a_r5_passthru: assert property (@(posedge clk) disable iff (rst)
        up_valid && !bp_q.v |-> dn_valid && dn_data == up_data);

    // R6: a held word that is not drained blocks upstream
    a_r6_full_block: assert property (@(posedge clk) disable iff (rst)
        bp_q.v && !dn_ready |-> !up_ready);

    // R1: a stalled held word is held steady
    a_r1_hold_stall: assert property (@(posedge clk) disable iff (rst)
        bp_q.v && !dn_ready |=> dn_valid && $stable(dn_data));

endmodule

// File: rtl/chan_buf.sv
module chan_buf
    import chan_buf_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int MODE  = MODE_SKID
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             up_valid,
    output logic             up_ready,
    input  logic [WIDTH-1:0] up_data,
    output logic             dn_valid,
    input  logic             dn_ready,
    output logic [WIDTH-1:0] dn_data,
    output logic             idle
);

    localparam int SLOTS = slots_of(MODE);

    logic [MAX_SLOTS-1:0] held;

    generate
        if (MODE == MODE_STAGE) begin : g_stage
            chan_buf_stage #(.WIDTH(WIDTH)) u_core (
                .clk(clk), .rst(rst),
                .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
                .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data),
                .held(held)
            );
        end else if (MODE == MODE_BYPASS) begin : g_bypass
            chan_buf_bypass #(.WIDTH(WIDTH)) u_core (
                .clk(clk), .rst(rst),
                .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
                .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data),
                .held(held)
            );
        end else begin : g_skid
            chan_buf_skid #(.WIDTH(WIDTH)) u_core (
                .clk(clk), .rst(rst),
                .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
                .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data),
                .held(held)
            );
        end
    endgenerate

    assign idle = !(up_valid || (|held));

    // R7: idle implies nothing offered and nothing presented
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        idle |-> !up_valid && !dn_valid);

    // R3 R4 R6: occupancy never exceeds the mode's capacity
    a_r6_capacity: assert property (@(posedge clk) disable iff (rst)
        $countones(held) <= SLOTS);

endmodule

// File: tb/chan_buf_tb.sv
`timescale 1ns/1ps
module chan_buf_tb;

    localparam int W     = 16;
    localparam int NMODE = 3;
    localparam int CYC   = 4000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         up_valid [NMODE];
    logic         up_ready [NMODE];
    logic [W-1:0] up_data  [NMODE];
    logic         dn_valid [NMODE];
    logic         dn_ready [NMODE];
    logic [W-1:0] dn_data  [NMODE];
    logic         idle     [NMODE];

    int wr_seq [NMODE];
    int rd_seq [NMODE];
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    for (genvar m = 0; m < NMODE; m++) begin : g_mode
        chan_buf #(.WIDTH(W), .MODE(m)) u_dut (
            .clk(clk), .rst(rst),
            .up_valid(up_valid[m]), .up_ready(up_ready[m]), .up_data(up_data[m]),
            .dn_valid(dn_valid[m]), .dn_ready(dn_ready[m]), .dn_data(dn_data[m]),
            .idle(idle[m])
        );
    end

    task automatic check(input bit ok, input string req, input int m,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s mode=%0d actual=%0d expected=%0d t=%0t",
                     req, m, act, exp, $time);
        end
    endtask

    function automatic int cap_of(input int m);
        return (m == 1) ? 2 : 1;
    endfunction

    function automatic bit exp_dn_valid(input int m, input int cnt, input bit uv);
        return (m == 2) ? (cnt > 0 || uv) : (cnt > 0);
    endfunction

    function automatic bit exp_up_ready(input int m, input int cnt, input bit dr);
        return (m == 1) ? (cnt < 2) : (cnt == 0 || dr);
    endfunction

    task automatic check_cycle();
        for (int m = 0; m < NMODE; m++) begin
            int cnt;
            bit ev;
            cnt = wr_seq[m] - rd_seq[m];
            ev  = exp_dn_valid(m, cnt, up_valid[m]);
            check(cnt <= cap_of(m), (m == 1) ? "R4" : ((m == 0) ? "R3" : "R6"),
                  m, cnt, cap_of(m));
            check(dn_valid[m] == ev, (m == 2) ? "R5" : ((m == 0) ? "R3" : "R4"),
                  m, dn_valid[m], ev);
            check(up_ready[m] == exp_up_ready(m, cnt, dn_ready[m]),
                  (m == 1) ? "R4" : "R9", m, up_ready[m],
                  exp_up_ready(m, cnt, dn_ready[m]));
            if (dn_valid[m]) begin
                // R2 order: presented word is the oldest outstanding one
                check(dn_data[m] == W'(rd_seq[m]), "R2", m, dn_data[m], rd_seq[m] % 65536);
            end
            check(idle[m] == (cnt == 0 && !up_valid[m]), "R7", m, idle[m],
                  cnt == 0 && !up_valid[m]);
            // R1: count transfers only on valid and ready
            if (up_valid[m] && up_ready[m]) wr_seq[m]++;
            if (dn_valid[m] && dn_ready[m]) rd_seq[m]++;
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int m = 0; m < NMODE; m++) begin
            up_valid[m] = 1'b1;
            dn_ready[m] = 1'b0;
            up_data[m]  = '0;
            wr_seq[m]   = 0;
            rd_seq[m]   = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        for (int m = 0; m < NMODE; m++) up_valid[m] = 1'b0;
        @(negedge clk);
        // R8: buffer empty right after reset
        for (int m = 0; m < NMODE; m++) begin
            check(dn_valid[m] == 1'b0, "R8", m, dn_valid[m], 0);
            check(idle[m] == 1'b1, "R8", m, idle[m], 1);
        end
        @(posedge clk);
        #1 rst = 1'b0;
        for (int c = 0; c < CYC; c++) begin
            int phase;
            phase = (c / 200) % 4;
            for (int m = 0; m < NMODE; m++) begin
                int pv, pr;
                case (phase)
                    0: begin pv = 50; pr = 50; end
                    1: begin pv = 90; pr = 8;  end
                    2: begin pv = 8;  pr = 90; end
                    default: begin pv = 100; pr = 100; end
                endcase
                up_valid[m] = ($urandom_range(99) < pv);
                dn_ready[m] = ($urandom_range(99) < pr);
                up_data[m]  = W'(wr_seq[m]);
            end
            @(negedge clk);
            check_cycle();
            @(posedge clk);
            #1;
        end
        // Directed drain: no input, consumer always ready.
        for (int c = 0; c < 6; c++) begin
            for (int m = 0; m < NMODE; m++) begin
                up_valid[m] = 1'b0;
                dn_ready[m] = 1'b1;
                up_data[m]  = W'(wr_seq[m]);
            end
            @(negedge clk);
            check_cycle();
            @(posedge clk);
            #1;
        end
        @(negedge clk);
        for (int m = 0; m < NMODE; m++) begin
            // R2: nothing lost, nothing duplicated
            check(wr_seq[m] == rd_seq[m], "R2", m, rd_seq[m], wr_seq[m]);
            check(wr_seq[m] > CYC / 4, "R2", m, wr_seq[m], CYC / 4);
            check(idle[m] == 1'b1, "R7", m, idle[m], 1);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule